// File: doc/BRIEF.md
# Sleep and Wake-Up Sequencer

This block decides what happens when the processor core executes its power-down instruction. It watches a strobe from the instruction decoder, a vector of peripheral interrupt flags with their matching enable bits, the global interrupt enable, a watchdog time-out pulse, an active-low external reset and an active-low power-on reset. It drives an enable for the oscillator (used as a gate on the core clock), a one-cycle watchdog clear, two status bits that software reads to find out why it is running, a resume pulse and a request to branch to the interrupt vector.

If an enabled interrupt is already pending when the strobe arrives, the power-down instruction is treated as a no-op and no status bit moves. Otherwise the block clears the watchdog, records the power-down, sets the time-out bit and turns the oscillator off. It stays asleep until an enabled interrupt or a watchdog time-out wakes it, or until the external reset pulls the core back into reset. The interrupt flags and the watchdog pulse are asynchronous to the sequencer clock and pass through two-flop synchronizers before they can act. The global interrupt enable does not gate wake-up. It only decides whether a vector request follows the resume, a fixed number of cycles later, so that the prefetched next instruction finishes first.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While the power-on reset `porN` is low, and in the first cycle after it is released, `pdBit` and `toBit` read 1, `oscEn` reads 1, and `wdtClear`, `resumePulse` and `vectorReq` read 0.
- R2: A `sleepExec` strobe taken at a clock edge with no enabled interrupt pending makes `oscEn` 0, `pdBit` 0 and `toBit` 1 after that edge, and makes `wdtClear` high for exactly that one cycle.
- R3: A `sleepExec` strobe taken while some flag bit i of `intFlags` and bit i of `intEnables` are both 1 (and have been for at least two clock edges) is a no-op. `oscEn` stays 1, `pdBit` and `toBit` keep their values and `wdtClear` stays 0.
- R4: A flag whose enable bit is 0 neither turns a `sleepExec` strobe into a no-op nor wakes the block from sleep.
- R5: While asleep, an enabled flag that rises between two clock edges produces `resumePulse` high for one cycle and `oscEn` 1 after the third following edge, not before. `pdBit` and `toBit` keep the values they had in sleep.
- R6: On an interrupt wake with `gie` 1, `vectorReq` is high for exactly one cycle, `VEC_DELAY` cycles after the `resumePulse` cycle. With `gie` 0 it stays 0.
- R7: While asleep, a one-cycle `wdtTimeout` pulse wakes the block with `resumePulse` after the third edge and clears `toBit`. No `vectorReq` follows, even with `gie` 1.
- R8: Driving `extRstN` low while asleep sets `oscEn` to 1 at once, gives no `resumePulse` and leaves `pdBit` and `toBit` unchanged.
- R9: A `wdtTimeout` pulse while awake has no effect on `toBit`, `pdBit`, `oscEn`, `resumePulse` or `wdtClear`.
- R10: An enabled flag that rises in the same cycle as the `sleepExec` strobe does not cancel the sleep. The full entry of R2 takes place, and `resumePulse` follows after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sequencer clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| extRstN | input | 1 | External reset, active low, asynchronous |
| sleepExec | input | 1 | One-cycle strobe: power-down instruction executing |
| intFlags | input | NUM_IRQ | Peripheral interrupt flags, asynchronous |
| intEnables | input | NUM_IRQ | Per-source interrupt enable bits |
| gie | input | 1 | Global interrupt enable |
| wdtTimeout | input | 1 | Watchdog time-out pulse, asynchronous |
| oscEn | output | 1 | Oscillator / core clock enable |
| wdtClear | output | 1 | One-cycle clear for the watchdog and its postscaler |
| pdBit | output | 1 | Power-down status bit |
| toBit | output | 1 | Time-out status bit |
| resumePulse | output | 1 | One-cycle pulse when execution resumes after sleep |
| vectorReq | output | 1 | One-cycle request to branch to the interrupt vector |

## Verification
A wrong sleep state shows up on `oscEn` in the cycle after the decision edge. A missing or doubled entry shows on `wdtClear` and on the status bits in that same cycle. A synchronizer with the wrong depth moves `resumePulse` off its third-edge slot, and a miscounted vector delay moves `vectorReq` off its slot `VEC_DELAY` cycles after the resume. A sweep over every enable mask and flag position checks the no-op decision against a pending-interrupt model. A stale status register would only surface at the next readout, so the status bits are compared after every step.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;
  // Decision strobes handed from the control FSM to the datapath.
  typedef struct packed {
    logic enterSleep;  // full power-down entry this cycle
    logic wakeNow;     // leaving sleep this cycle
    logic wdtWake;     // wake caused by watchdog time-out
    logic armVector;   // schedule a branch to the interrupt vector
  } swStrobes_t;
endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= asyncIn;
      stage2 <= stage1;
    end
  end

  assign syncOut = stage2;
endmodule

// File: rtl/sw_ctrl.sv
module sw_ctrl
  import sleep_wake_pkg::*;
(
  input  logic       clk,
  input  logic       coreRstN,
  input  logic       sleepExec,
  input  logic       gie,
  input  logic       pendSync,
  input  logic       wdtSync,
  output logic       asleep,
  output swStrobes_t strobes
);
  always_comb begin
    strobes.enterSleep = !asleep && sleepExec && !pendSync;
    strobes.wakeNow    = asleep && (pendSync || wdtSync);
    strobes.wdtWake    = asleep && wdtSync;
    strobes.armVector  = asleep && pendSync && gie;
  end

  always_ff @(posedge clk or negedge coreRstN) begin
    if (!coreRstN)               asleep <= 1'b0;
    else if (strobes.enterSleep) asleep <= 1'b1;
    else if (strobes.wakeNow)    asleep <= 1'b0;
  end
endmodule

// File: rtl/sw_datapath.sv
module sw_datapath
  import sleep_wake_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int VEC_DELAY = 4
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               coreRstN,
  input  logic [NUM_IRQ-1:0] intFlags,
  input  logic [NUM_IRQ-1:0] intEnables,
  input  logic               wdtTimeout,
  input  swStrobes_t         strobes,
  output logic               pendSync,
  output logic               wdtSync,
  output logic               wdtClear,
  output logic               pdBit,
  output logic               toBit,
  output logic               resumePulse,
  output logic               vectorReq
);
  localparam int CNT_W = $clog2(VEC_DELAY + 1);

  logic [NUM_IRQ-1:0] flagSync;
  logic [CNT_W-1:0]   vecCnt;

  sw_sync #(.WIDTH(NUM_IRQ)) uFlagSync (
    .clk(clk), .rstN(porN), .asyncIn(intFlags), .syncOut(flagSync)
  );
  sw_sync #(.WIDTH(1)) uWdtSync (
    .clk(clk), .rstN(porN), .asyncIn(wdtTimeout), .syncOut(wdtSync)
  );

  assign pendSync = |(flagSync & intEnables);

  // Status bits survive the external reset; only power-on sets them.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      pdBit <= 1'b1;
      toBit <= 1'b1;
    end else if (strobes.enterSleep) begin
      pdBit <= 1'b0;
      toBit <= 1'b1;
    end else if (strobes.wdtWake) begin
      toBit <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge coreRstN) begin
    if (!coreRstN) begin
      wdtClear    <= 1'b0;
      resumePulse <= 1'b0;
      vectorReq   <= 1'b0;
      vecCnt      <= '0;
    end else begin
      wdtClear    <= strobes.enterSleep;
      resumePulse <= strobes.wakeNow;
      vectorReq   <= (vecCnt == CNT_W'(1));
      if (strobes.armVector)   vecCnt <= CNT_W'(VEC_DELAY);
      else if (vecCnt != '0)   vecCnt <= vecCnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import sleep_wake_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int VEC_DELAY = 4
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               extRstN,
  input  logic               sleepExec,
  input  logic [NUM_IRQ-1:0] intFlags,
  input  logic [NUM_IRQ-1:0] intEnables,
  input  logic               gie,
  input  logic               wdtTimeout,
  output logic               oscEn,
  output logic               wdtClear,
  output logic               pdBit,
  output logic               toBit,
  output logic               resumePulse,
  output logic               vectorReq
);
  logic       coreRstN;
  logic       asleep;
  logic       pendSync;
  logic       wdtSync;
  swStrobes_t strobes;

  assign coreRstN = porN & extRstN;
  assign oscEn    = !asleep;

  sw_ctrl uCtrl (
    .clk(clk), .coreRstN(coreRstN), .sleepExec(sleepExec), .gie(gie),
    .pendSync(pendSync), .wdtSync(wdtSync), .asleep(asleep), .strobes(strobes)
  );

  sw_datapath #(.NUM_IRQ(NUM_IRQ), .VEC_DELAY(VEC_DELAY)) uData (
    .clk(clk), .porN(porN), .coreRstN(coreRstN), .intFlags(intFlags),
    .intEnables(intEnables), .wdtTimeout(wdtTimeout), .strobes(strobes),
    .pendSync(pendSync), .wdtSync(wdtSync), .wdtClear(wdtClear),
    .pdBit(pdBit), .toBit(toBit), .resumePulse(resumePulse),
    .vectorReq(vectorReq)
  );
endmodule

// File: rtl/sleep_wake_checker.sv
module sleep_wake_checker (
  input logic clk,
  input logic porN,
  input logic extRstN,
  input logic oscEn,
  input logic wdtClear,
  input logic pdBit,
  input logic toBit,
  input logic resumePulse,
  input logic vectorReq
);
  p_clear_single_r2: assert property (@(posedge clk) disable iff (!porN || !extRstN)
    wdtClear |=> !wdtClear);

  p_entry_state_r2: assert property (@(posedge clk) disable iff (!porN || !extRstN)
    wdtClear |-> (!oscEn && !pdBit && toBit));

  p_pd_falls_on_entry_r2: assert property (@(posedge clk) disable iff (!porN || !extRstN)
    $fell(pdBit) |-> wdtClear);

  p_osc_off_on_entry_r2: assert property (@(posedge clk) disable iff (!porN || !extRstN)
    $fell(oscEn) |-> wdtClear);

  p_resume_single_r5: assert property (@(posedge clk) disable iff (!porN || !extRstN)
    resumePulse |=> !resumePulse);

  p_resume_running_r5: assert property (@(posedge clk) disable iff (!porN || !extRstN)
    resumePulse |-> oscEn);

  p_vector_apart_r6: assert property (@(posedge clk) disable iff (!porN || !extRstN)
    vectorReq |-> (oscEn && !resumePulse));

  p_to_clear_on_wake_r7: assert property (@(posedge clk) disable iff (!porN || !extRstN)
    $fell(toBit) |-> resumePulse);
endmodule

bind sleep_wake_ctrl sleep_wake_checker uChecker (
  .clk(clk), .porN(porN), .extRstN(extRstN), .oscEn(oscEn),
  .wdtClear(wdtClear), .pdBit(pdBit), .toBit(toBit),
  .resumePulse(resumePulse), .vectorReq(vectorReq)
);

// File: tb/sleep_wake_ctrl_test.sv
module sleep_wake_ctrl_test;
  localparam int NIRQ = 3;
  localparam int VD   = 4;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic extRstN = 1'b1;
  logic sleepExec = 1'b0;
  logic [NIRQ-1:0] intFlags = '0;
  logic [NIRQ-1:0] intEnables = '0;
  logic gie = 1'b0;
  logic wdtTimeout = 1'b0;
  logic oscEn, wdtClear, pdBit, toBit, resumePulse, vectorReq;

  int checks = 0;
  int fails = 0;
  logic expPd = 1'b1;
  logic expTo = 1'b1;

  always #5 clk = ~clk;

  sleep_wake_ctrl #(.NUM_IRQ(NIRQ), .VEC_DELAY(VD)) uut (
    .clk(clk), .porN(porN), .extRstN(extRstN), .sleepExec(sleepExec),
    .intFlags(intFlags), .intEnables(intEnables), .gie(gie),
    .wdtTimeout(wdtTimeout), .oscEn(oscEn), .wdtClear(wdtClear),
    .pdBit(pdBit), .toBit(toBit), .resumePulse(resumePulse),
    .vectorReq(vectorReq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic sleepStrobe();
    sleepExec = 1'b1;
    tick(1);
    sleepExec = 1'b0;
  endtask

  // Wake from sleep with a one-cycle watchdog pulse; resume after third edge.
  task automatic wdtWakeUp(input string req);
    wdtTimeout = 1'b1;
    tick(1);
    wdtTimeout = 1'b0;
    tick(1);
    check(req, "resume early", resumePulse, 1'b0);
    tick(1);
    check(req, "resume", resumePulse, 1'b1);
    check(req, "osc", oscEn, 1'b1);
    check(req, "to", toBit, 1'b0);
    check(req, "pd", pdBit, expPd);
    expTo = 1'b0;
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog run hung actual=running expected=done");
    finishRun();
  end

  initial begin
    // R1 reset state
    tick(3);
    check("R1", "pd in reset", pdBit, 1'b1);
    check("R1", "to in reset", toBit, 1'b1);
    check("R1", "osc in reset", oscEn, 1'b1);
    porN = 1'b1;
    tick(1);
    check("R1", "pd", pdBit, 1'b1);
    check("R1", "to", toBit, 1'b1);
    check("R1", "osc", oscEn, 1'b1);
    check("R1", "clear", wdtClear, 1'b0);
    check("R1", "resume", resumePulse, 1'b0);
    check("R1", "vector", vectorReq, 1'b0);

    // Sweep: every enable mask against every single flag position (R2 R3 R4 R7)
    for (int mask = 0; mask < (1 << NIRQ); mask++) begin
      for (int idx = 0; idx < NIRQ; idx++) begin
        intEnables = NIRQ'(mask);
        intFlags   = NIRQ'(1 << idx);
        gie        = 1'b0;
        tick(3);
        sleepStrobe();
        if (mask[idx]) begin
          check("R3", "osc noop", oscEn, 1'b1);
          check("R3", "pd noop", pdBit, expPd);
          check("R3", "to noop", toBit, expTo);
          check("R3", "clear noop", wdtClear, 1'b0);
          tick(1);
          check("R3", "osc later", oscEn, 1'b1);
        end else begin
          check("R2", "osc off", oscEn, 1'b0);
          check("R2", "pd", pdBit, 1'b0);
          check("R2", "to", toBit, 1'b1);
          check("R2", "clear", wdtClear, 1'b1);
          expPd = 1'b0;
          expTo = 1'b1;
          tick(1);
          check("R2", "clear single", wdtClear, 1'b0);
          tick(4);
          check("R4", "disabled flag no wake", oscEn, 1'b0);
          check("R4", "no resume", resumePulse, 1'b0);
          wdtWakeUp("R7");
          tick(1);
          check("R7", "resume single", resumePulse, 1'b0);
        end
        intFlags = '0;
        tick(3);
      end
    end

    // Interrupt wake, GIE off and on (R5 R6)
    for (int g = 0; g < 2; g++) begin
      intEnables = 3'b010;
      intFlags   = '0;
      gie        = g[0];
      sleepStrobe();
      check("R5", "asleep", oscEn, 1'b0);
      expPd = 1'b0;
      expTo = 1'b1;
      tick(2);
      intFlags = 3'b010;
      tick(2);
      check("R5", "resume before sync", resumePulse, 1'b0);
      check("R5", "osc before sync", oscEn, 1'b0);
      tick(1);
      check("R5", "resume", resumePulse, 1'b1);
      check("R5", "osc", oscEn, 1'b1);
      check("R5", "pd kept", pdBit, expPd);
      check("R5", "to kept", toBit, expTo);
      for (int k = 1; k <= VD + 1; k++) begin
        tick(1);
        check("R6", "vector slot", vectorReq, (g == 1) && (k == VD));
        if (k == 1) check("R5", "resume single", resumePulse, 1'b0);
      end
      intFlags = '0;
      tick(3);
    end

    // Watchdog wake never requests the vector (R7)
    gie = 1'b1;
    intEnables = '1;
    sleepStrobe();
    expTo = 1'b1;
    tick(2);
    wdtWakeUp("R7");
    for (int k = 1; k <= VD + 1; k++) begin
      tick(1);
      check("R7", "no vector", vectorReq, 1'b0);
    end

    // Flag rising with the strobe: sleep completes then wakes (R10)
    gie = 1'b0;
    intEnables = 3'b001;
    sleepExec = 1'b1;
    intFlags = 3'b001;
    tick(1);
    sleepExec = 1'b0;
    check("R10", "osc off", oscEn, 1'b0);
    check("R10", "pd", pdBit, 1'b0);
    check("R10", "to", toBit, 1'b1);
    check("R10", "clear", wdtClear, 1'b1);
    expTo = 1'b1;
    tick(2);
    check("R10", "resume", resumePulse, 1'b1);
    check("R10", "osc on", oscEn, 1'b1);
    intFlags = '0;
    tick(3);

    // Watchdog pulse while awake (R9)
    wdtTimeout = 1'b1;
    tick(1);
    wdtTimeout = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick(1);
      check("R9", "to", toBit, expTo);
      check("R9", "pd", pdBit, expPd);
      check("R9", "osc", oscEn, 1'b1);
      check("R9", "resume", resumePulse, 1'b0);
      check("R9", "clear", wdtClear, 1'b0);
    end

    // External reset during sleep (R8)
    intEnables = '0;
    sleepStrobe();
    check("R8", "asleep", oscEn, 1'b0);
    tick(1);
    extRstN = 1'b0;
    #1;
    check("R8", "osc on", oscEn, 1'b1);
    check("R8", "resume", resumePulse, 1'b0);
    check("R8", "pd kept", pdBit, 1'b0);
    check("R8", "to kept", toBit, 1'b1);
    tick(2);
    extRstN = 1'b1;
    tick(1);
    check("R8", "osc after", oscEn, 1'b1);
    check("R8", "resume after", resumePulse, 1'b0);
    check("R8", "pd after", pdBit, 1'b0);
    check("R8", "to after", toBit, 1'b1);

    // Power-on reset sets PD again (R1)
    porN = 1'b0;
    tick(1);
    check("R1", "pd restored", pdBit, 1'b1);
    check("R1", "to restored", toBit, 1'b1);
    porN = 1'b1;
    tick(2);
    finishRun();
  end
endmodule